// File: doc/BRIEF.md
# Ping-Pong Sample Storage Controller

This block drives the digital side of a deep switched-capacitor waveform memory that samples in two stages. A fast sample strobe walks a single write position across one bank of 64 sampling lanes. The other bank holds its previous 64 samples while they are copied into the deep store. When the recording bank has taken its 64th sample, the two banks swap roles. The controller then issues one transfer pulse. The pulse carries the number of the bank that has just filled and the storage group that receives it. The deep store is a ring of 512 groups, each holding one bank's worth of cells. Recording and transfer carry on while the store is being read out.

A trigger input freezes history. On a trigger, the controller latches the group written most recently and protects it, together with up to seven older neighbours. The span is programmable from 1 to 8 groups. It reports the frozen range on `mark_base` and `mark_len` so that digitization can fetch it. Later transfers step past protected groups. Triggers add to the protected set until a readout-done pulse releases every protected group at once. If no unprotected group is left, the controller raises overflow and drops transfers. Sampling into the lanes continues, and the write position stays where it is.

The control state machine has three states. In `ST_RUN` nothing is protected. In `ST_HOLD` at least one group is protected and transfers still find room. In `ST_FULL` a transfer found no free group. `ST_RUN` goes to `ST_HOLD` when a trigger arrives. `ST_HOLD` goes back to `ST_RUN` on readout-done without a trigger in the same cycle. `ST_RUN` or `ST_HOLD` goes to `ST_FULL` when a bank completes and no free group exists. `ST_FULL` leaves only on readout-done, going to `ST_HOLD` if a trigger comes in the same cycle and to `ST_RUN` otherwise.

Top module: `pingpong_store_ctrl`

## Requirements
- R1: After reset, `rec_lane`=0, `rec_bank`=0, `xfer_pulse`=0, `frozen`=0, `overflow`=0 and `mark_len`=0. The first transfer after reset goes to group 0.
- R2: Each clock with `smp_strobe` high advances `rec_lane` by one. A strobe at lane 63 returns `rec_lane` to 0 and inverts `rec_bank`, even while transfers are being dropped.
- R3: The cycle after the strobe that fills lane 63, `xfer_pulse` is high for exactly one cycle. In that cycle `xfer_bank` equals the bank that has just filled (0 or 1), which is the opposite of the new `rec_bank`.
- R4: When no group is protected, successive transfers use groups in rising order, and group 511 is followed by group 0.
- R5: A trigger sets `mark_base` to the group of the most recent transfer (511 if none has occurred), sets `mark_len` to `lookback`+1 (`lookback` 0..7 gives 1..8 groups), and sets `frozen` high on the next cycle. The groups `mark_base`, `mark_base`-1, ..., `mark_base`-`lookback` (mod 512) become protected.
- R6: A transfer goes to the first unprotected group after the last written group, in rising modular order, skipping every protected group.
- R7: A `rd_done` pulse releases all protected groups. On the next cycle `frozen` and `overflow` are low, unless a trigger arrived in the same cycle.
- R8: When a bank completes and every group is protected, no transfer pulse is issued, `overflow` goes high and the last written group is unchanged. After release, the next transfer goes to the group following that last written group.
- R9: A trigger in the same cycle as a completing strobe latches the group written before that transfer, while the transfer itself still proceeds. A trigger in the same cycle as `rd_done` is applied after the release, so `frozen` stays high with the new range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_strobe | input | 1 | One sample into the current lane |
| trig | input | 1 | Freeze request |
| lookback | input | 3 | Protected span minus one |
| rd_done | input | 1 | Release all protected groups |
| rec_bank | output | 1 | Bank currently recording |
| rec_lane | output | 6 | Lane taking the next sample |
| xfer_pulse | output | 1 | Bank-to-store transfer strobe |
| xfer_bank | output | 1 | Bank being transferred |
| xfer_group | output | 9 | Destination storage group |
| mark_base | output | 9 | Newest group of the last frozen range |
| mark_len | output | 4 | Number of groups in that range |
| frozen | output | 1 | Protected groups await readout |
| overflow | output | 1 | Transfers dropped, store full |

## Verification
Two things can happen in the same clock: a trigger and the completion of a bank. That case decides whether the frozen range ends at the group written before the swap or at the group just being written. The bench raises `trig` on the 64th strobe of a bank. It then expects `xfer_group` to show the new destination while `mark_base` holds the previous group. A second collision, between release and trigger, is provoked by pulsing `rd_done` and `trig` together. The bench judges it by `frozen` staying high and `mark_base`/`mark_len` taking the new range.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_FULL = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/pps_lane_seq.sv
module pps_lane_seq #(
    parameter int LANES = 64,
    localparam int LW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_strobe,
    output logic          rec_bank,
    output logic [LW-1:0] rec_lane,
    output logic          bank_done
);
    // a bank is complete when its last lane takes a sample
    assign bank_done = smp_strobe && (rec_lane == LW'(LANES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_lane <= '0;
            rec_bank <= 1'b0;
        end else if (smp_strobe) begin
            if (bank_done) begin
                rec_lane <= '0;
                rec_bank <= ~rec_bank;
            end else begin
                rec_lane <= rec_lane + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pps_group_guard.sv
module pps_group_guard #(
    parameter int NGROUPS = 512,
    parameter int MAX_LB  = 8,
    localparam int GW  = $clog2(NGROUPS),
    localparam int LBW = $clog2(MAX_LB)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [GW-1:0]  set_top,
    input  logic [LBW-1:0] set_len_m1,
    input  logic           clr_all,
    input  logic [GW-1:0]  cur_grp,
    output logic [GW-1:0]  next_grp,
    output logic           next_ok,
    output logic           any_prot
);
    logic [NGROUPS-1:0] prot_q;
    logic [NGROUPS-1:0] set_vec;
    logic [NGROUPS-1:0] prot_d;
    logic [GW-1:0]      cand;

    // window of newly protected groups, ending at set_top
    always_comb begin
        set_vec = '0;
        if (set_en) begin
            for (int j = 0; j < MAX_LB; j++) begin
                if (j <= int'(set_len_m1)) set_vec[set_top - GW'(j)] = 1'b1;
            end
        end
    end

    // release first, then add the new window
    assign prot_d   = (clr_all ? '0 : prot_q) | set_vec;
    assign any_prot = |prot_d;

    // nearest free group after cur_grp; the last candidate is cur_grp itself
    always_comb begin
        next_ok  = 1'b0;
        next_grp = cur_grp;
        cand     = cur_grp;
        for (int i = NGROUPS; i >= 1; i--) begin
            cand = cur_grp + GW'(i);
            if (!prot_d[cand]) begin
                next_ok  = 1'b1;
                next_grp = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= '0;
        else        prot_q <= prot_d;
    end
endmodule

// File: rtl/pingpong_store_ctrl.sv
module pingpong_store_ctrl
    import pps_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int NGROUPS = 512,
    parameter int MAX_LB  = 8,
    localparam int LW  = $clog2(LANES),
    localparam int GW  = $clog2(NGROUPS),
    localparam int LBW = $clog2(MAX_LB)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_strobe,
    input  logic           trig,
    input  logic [LBW-1:0] lookback,
    input  logic           rd_done,
    output logic           rec_bank,
    output logic [LW-1:0]  rec_lane,
    output logic           xfer_pulse,
    output logic           xfer_bank,
    output logic [GW-1:0]  xfer_group,
    output logic [GW-1:0]  mark_base,
    output logic [LBW:0]   mark_len,
    output logic           frozen,
    output logic           overflow
);
    ctl_state_e    state_q, state_d;
    logic          bank_done;
    logic [GW-1:0] wr_grp;
    logic [GW-1:0] next_grp;
    logic          next_ok;
    logic          any_prot;
    logic          xfer_go;

    pps_lane_seq #(.LANES(LANES)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_strobe (smp_strobe),
        .rec_bank   (rec_bank),
        .rec_lane   (rec_lane),
        .bank_done  (bank_done)
    );

    pps_group_guard #(.NGROUPS(NGROUPS), .MAX_LB(MAX_LB)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (trig),
        .set_top    (wr_grp),
        .set_len_m1 (lookback),
        .clr_all    (rd_done),
        .cur_grp    (wr_grp),
        .next_grp   (next_grp),
        .next_ok    (next_ok),
        .any_prot   (any_prot)
    );

    assign xfer_go = bank_done && next_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_HOLD: begin
                if (bank_done && !next_ok) state_d = ST_FULL;
                else if (any_prot)         state_d = ST_HOLD;
                else                       state_d = ST_RUN;
            end
            ST_FULL: begin
                if (!rd_done)                   state_d = ST_FULL;
                else if (bank_done && !next_ok) state_d = ST_FULL;
                else if (any_prot)              state_d = ST_HOLD;
                else                            state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_pulse <= 1'b0;
            xfer_bank  <= 1'b0;
            xfer_group <= '0;
            wr_grp     <= GW'(NGROUPS - 1);
            mark_base  <= '0;
            mark_len   <= '0;
        end else begin
            xfer_pulse <= xfer_go;
            if (xfer_go) begin
                xfer_bank  <= rec_bank;
                xfer_group <= next_grp;
                wr_grp     <= next_grp;
            end
            if (trig) begin
                mark_base <= wr_grp;
                mark_len  <= {1'b0, lookback} + 1'b1;
            end
        end
    end

    assign frozen   = (state_q != ST_RUN);
    assign overflow = (state_q == ST_FULL);
endmodule

// File: rtl/pps_sva.sv
module pps_sva #(
    parameter int LANES = 64,
    parameter int GW    = 9,
    localparam int LW = $clog2(LANES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_strobe,
    input logic          trig,
    input logic          rd_done,
    input logic          rec_bank,
    input logic [LW-1:0] rec_lane,
    input logic          xfer_pulse,
    input logic          xfer_bank,
    input logic [GW-1:0] xfer_group,
    input logic          frozen,
    input logic          overflow
);
    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_strobe && rec_lane != LW'(LANES - 1) |=> rec_lane == LW'($past(rec_lane) + 1'b1)); // R2
    AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_strobe && rec_lane == LW'(LANES - 1) |=> rec_lane == '0 && rec_bank != $past(rec_bank)); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pulse |=> !xfer_pulse); // R3
    AST_PULSE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pulse |-> xfer_bank != rec_bank && rec_lane == '0); // R3
    AST_TRIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> frozen); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && !trig |=> !frozen && !overflow); // R7
    AST_NO_OVERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !xfer_pulse); // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !rd_done |=> overflow && $stable(xfer_group)); // R8
endmodule

bind pingpong_store_ctrl pps_sva #(.LANES(LANES), .GW(GW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_strobe (smp_strobe),
    .trig       (trig),
    .rd_done    (rd_done),
    .rec_bank   (rec_bank),
    .rec_lane   (rec_lane),
    .xfer_pulse (xfer_pulse),
    .xfer_bank  (xfer_bank),
    .xfer_group (xfer_group),
    .frozen     (frozen),
    .overflow   (overflow)
);

// File: tb/pingpong_store_ctrl_tb.sv
`timescale 1ns/1ps
module pingpong_store_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_strobe = 1'b0;
    logic       trig = 1'b0;
    logic [2:0] lookback = 3'd0;
    logic       rd_done = 1'b0;
    logic       rec_bank;
    logic [5:0] rec_lane;
    logic       xfer_pulse;
    logic       xfer_bank;
    logic [8:0] xfer_group;
    logic [8:0] mark_base;
    logic [3:0] mark_len;
    logic       frozen;
    logic       overflow;

    int n_chk = 0;
    int n_bad = 0;
    int banks = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    pingpong_store_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .trig(trig),
        .lookback(lookback), .rd_done(rd_done), .rec_bank(rec_bank),
        .rec_lane(rec_lane), .xfer_pulse(xfer_pulse), .xfer_bank(xfer_bank),
        .xfer_group(xfer_group), .mark_base(mark_base), .mark_len(mark_len),
        .frozen(frozen), .overflow(overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // 64 strobes starting at a falling edge; optional trigger on the last one
    task automatic run_bank(input bit trig_last, input logic [2:0] lb_last);
        for (int k = 0; k < 64; k++) begin
            smp_strobe = 1'b1;
            if (k == 63 && trig_last) begin
                trig = 1'b1;
                lookback = lb_last;
            end
            @(negedge clk);
        end
        smp_strobe = 1'b0;
        trig = 1'b0;
        banks++;
    endtask

    task automatic pulse_trig(input logic [2:0] lb);
        trig = 1'b1;
        lookback = lb;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic pulse_release();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        banks = 0;
        chk("R1 rec_lane", int'(rec_lane), 0);
        chk("R1 rec_bank", int'(rec_bank), 0);
        chk("R1 xfer_pulse", int'(xfer_pulse), 0);
        chk("R1 frozen", int'(frozen), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 mark_len", int'(mark_len), 0);
    endtask

    task automatic t_lanes();
        smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
        chk("R2 lane after one strobe", int'(rec_lane), 1);
        chk("R2 bank after one strobe", int'(rec_bank), 0);
        chk("R3 no early pulse", int'(xfer_pulse), 0);
        for (int k = 0; k < 63; k++) begin
            smp_strobe = 1'b1;
            @(negedge clk);
        end
        smp_strobe = 1'b0;
        banks++;
        chk("R2 lane wraps", int'(rec_lane), 0);
        chk("R2 bank swaps", int'(rec_bank), 1);
        chk("R3 pulse", int'(xfer_pulse), 1);
        chk("R3 bank sent", int'(xfer_bank), 0);
        chk("R1 first group", int'(xfer_group), 0);
        @(negedge clk);
        chk("R3 pulse one cycle", int'(xfer_pulse), 0);
    endtask

    // groups 1..9, freeze 9..7, then wrap and skip the frozen range
    task automatic t_wrap_skip();
        int e;
        for (int g = 1; g <= 9; g++) begin
            int bexp;
            bexp = banks % 2;
            run_bank(1'b0, 3'd0);
            chk("R4 pulse", int'(xfer_pulse), 1);
            chk("R4 group", int'(xfer_group), g);
            chk("R3 bank", int'(xfer_bank), bexp);
        end
        pulse_trig(3'd2);
        chk("R5 mark_base", int'(mark_base), 9);
        chk("R5 mark_len", int'(mark_len), 3);
        chk("R5 frozen", int'(frozen), 1);
        e = 9;
        for (int n = 0; n < 510; n++) begin
            e = (e + 1) % 512;
            if (e >= 7 && e <= 9) e = 10;
            run_bank(1'b0, 3'd0);
            chk("R4 R6 pulse", int'(xfer_pulse), 1);
            chk("R4 R6 group", int'(xfer_group), e);
        end
        chk("R6 landed after skip", int'(xfer_group), 10);
        pulse_release();
        chk("R7 frozen cleared", int'(frozen), 0);
        chk("R7 overflow clear", int'(overflow), 0);
    endtask

    // fill the whole store with frozen ranges, then overflow
    task automatic t_overflow();
        int e;
        e = 10;
        for (int r = 0; r < 64; r++) begin
            for (int k = 0; k < 8; k++) begin
                e = (e + 1) % 512;
                run_bank(1'b0, 3'd0);
                chk("R8 fill pulse", int'(xfer_pulse), 1);
                chk("R8 fill group", int'(xfer_group), e);
            end
            pulse_trig(3'd7);
            chk("R5 mark_base", int'(mark_base), e);
            chk("R5 mark_len", int'(mark_len), 8);
        end
        run_bank(1'b0, 3'd0);
        chk("R8 dropped pulse", int'(xfer_pulse), 0);
        chk("R8 overflow set", int'(overflow), 1);
        chk("R8 frozen set", int'(frozen), 1);
        run_bank(1'b0, 3'd0);
        chk("R8 still dropped", int'(xfer_pulse), 0);
        chk("R2 bank toggles while full", int'(rec_bank), banks % 2);
        chk("R8 group held", int'(xfer_group), 10);
        pulse_release();
        chk("R7 overflow cleared", int'(overflow), 0);
        chk("R7 frozen cleared", int'(frozen), 0);
        run_bank(1'b0, 3'd0);
        chk("R8 resume pulse", int'(xfer_pulse), 1);
        chk("R8 resume group", int'(xfer_group), 11);
    endtask

    task automatic t_collide();
        run_bank(1'b1, 3'd0);
        chk("R9 transfer proceeds", int'(xfer_pulse), 1);
        chk("R9 transfer group", int'(xfer_group), 12);
        chk("R9 mark_base old group", int'(mark_base), 11);
        chk("R9 mark_len", int'(mark_len), 1);
        chk("R9 frozen", int'(frozen), 1);
        rd_done = 1'b1;
        trig = 1'b1;
        lookback = 3'd1;
        @(negedge clk);
        rd_done = 1'b0;
        trig = 1'b0;
        chk("R9 frozen kept", int'(frozen), 1);
        chk("R9 new base", int'(mark_base), 12);
        chk("R9 new len", int'(mark_len), 2);
        chk("R9 no overflow", int'(overflow), 0);
    endtask

    initial begin
        #(8.0 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lanes();
        t_wrap_skip();
        t_overflow();
        t_collide();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule